// File: doc/BRIEF.md
# CAN Low-Power Mode Sequencer

This block decides when a CAN protocol controller goes into or comes out of its Sleep and Freeze modes. Software asks for a mode with a level request. The sequencer grants the request only when the controller is idle on the bus. It reports the grant on an acknowledge output. When software drops the request, the acknowledge stays high until the bus has been seen idle for a fixed run of recessive bits. The receive path supplies the sampled RX level and a strobe once per bit time.

The block also holds two sticky interrupt flags:
- A wakeup flag, set when a start-of-frame is detected while the controller is asleep.
- An error flag, set when any enabled error-status source is active.

Software clears either flag by writing a one to it. A registered status-change interrupt output summarises the flags that are both set and enabled.

The controller leaves reset in Sleep mode.

Top module: `can_lpm_seq`

## Requirements
- R1: After reset, sleepAck is 1, freezeAck is 0, and wakeFlag, errFlag and statusIrq are all 0.
- R2: In normal mode, a mode is entered at the clock edge where its request is high and busBusy is low, so its acknowledge reads 1 after that edge. While busBusy is high, no mode is entered. When both requests are high, Freeze is entered.
- R3: The exit wait starts once a mode's request goes low. The acknowledge clears at the clock edge that samples the RUN_LEN-th (default 11) consecutive recessive bit, meaning bitStrobe=1 with rxBit=1. If the request returns high during the wait, the mode is kept.
- R4: During the exit wait, a dominant bit (bitStrobe=1, rxBit=0) restarts the run count from zero. An rxBit value without bitStrobe has no effect on the count.
- R5: If a mode request is withdrawn before entry was granted, the controller stays in normal mode and neither acknowledge rises.
- R6: sofPulse sets wakeFlag only while sleepAck is 1. While sleepAck is 0, sofPulse has no effect.
- R7: errFlag is set at the edge where any bit i has both errStatus[i] and errIntEn[i] high. It is not set otherwise.
- R8: A cycle with flagWrEn=1 clears wakeFlag when flagWrData[0]=1 and clears errFlag when flagWrData[1]=1. A 0 in either bit leaves that flag unchanged.
- R9: If a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: statusIrq equals the value of (wakeFlag AND wakeIntEn) OR errFlag from one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Software Sleep request level |
| freezeReq | input | 1 | Software Freeze request level |
| busBusy | input | 1 | A transmission or reception is in progress |
| rxBit | input | 1 | Sampled RX level (1 = recessive) |
| bitStrobe | input | 1 | One-cycle strobe per bit time qualifying rxBit |
| sofPulse | input | 1 | Start-of-frame detected |
| errStatus | input | ERR_SRC | Error-status sources |
| errIntEn | input | ERR_SRC | Per-source error interrupt enables |
| wakeIntEn | input | 1 | Wakeup interrupt enable |
| flagWrEn | input | 1 | Flag write strobe |
| flagWrData | input | 2 | Write-one-to-clear data: bit0 wakeup, bit1 error |
| sleepAck | output | 1 | Sleep mode acknowledge |
| freezeAck | output | 1 | Freeze mode acknowledge |
| wakeFlag | output | 1 | Wakeup flag |
| errFlag | output | 1 | Error flag |
| statusIrq | output | 1 | Registered status-change interrupt |

## Verification
The bench builds the block with its defaults: RUN_LEN=11 and ERR_SRC=3. With these values the exact 11-bit exit boundary is visible, as is a dominant bit that interrupts the run one bit before completion. Every error source can be paired with its own enable bit. Random request toggling with mostly recessive, frequently strobed RX completes many exit waits. Random SOF pulses and flag writes regularly make a hardware set collide with a software clear.

// File: rtl/can_lpm_pkg.sv
package can_lpm_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL      = 3'd0,
    MODE_SLEEP       = 3'd1,
    MODE_SLEEP_EXIT  = 3'd2,
    MODE_FREEZE      = 3'd3,
    MODE_FREEZE_EXIT = 3'd4
  } lpMode_t;

  // strobes from the mode control to the datapath
  typedef struct packed {
    logic exitWait;     // an exit wait is in progress, count recessive bits
    logic sleepActive;  // sleep acknowledged, SOF may wake
  } ctrlStrobe_t;

endpackage

// File: rtl/can_lpm_ctrl.sv
module can_lpm_ctrl
  import can_lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepReq,
  input  logic        freezeReq,
  input  logic        busBusy,
  input  logic        runDone,
  output ctrlStrobe_t strobes,
  output logic        sleepAck,
  output logic        freezeAck
);

  lpMode_t modeQ, modeD;

  always_comb begin
    modeD = modeQ;
    unique case (modeQ)
      MODE_NORMAL: begin
        if (!busBusy) begin
          if (freezeReq)     modeD = MODE_FREEZE;
          else if (sleepReq) modeD = MODE_SLEEP;
        end
      end
      MODE_SLEEP:       if (!sleepReq) modeD = MODE_SLEEP_EXIT;
      MODE_SLEEP_EXIT: begin
        if (sleepReq)     modeD = MODE_SLEEP;
        else if (runDone) modeD = MODE_NORMAL;
      end
      MODE_FREEZE:      if (!freezeReq) modeD = MODE_FREEZE_EXIT;
      MODE_FREEZE_EXIT: begin
        if (freezeReq)    modeD = MODE_FREEZE;
        else if (runDone) modeD = MODE_NORMAL;
      end
      default:          modeD = MODE_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_SLEEP;
    else       modeQ <= modeD;
  end

  assign sleepAck  = (modeQ == MODE_SLEEP)  || (modeQ == MODE_SLEEP_EXIT);
  assign freezeAck = (modeQ == MODE_FREEZE) || (modeQ == MODE_FREEZE_EXIT);

  assign strobes.exitWait    = (modeQ == MODE_SLEEP_EXIT) || (modeQ == MODE_FREEZE_EXIT);
  assign strobes.sleepActive = sleepAck;

  // R2: no entry while the bus is busy
  p_no_entry_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_NORMAL && busBusy) |=> (!sleepAck && !freezeAck));

  // R3: an acknowledge only drops after a completed recessive run
  p_exit_needs_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((sleepAck || freezeAck) && !runDone) |=> (sleepAck || freezeAck));

  // R2: the two acknowledges are never both set
  p_ack_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(sleepAck && freezeAck));

endmodule

// File: rtl/can_lpm_dp.sv
module can_lpm_dp
  import can_lpm_pkg::*;
#(
  parameter int RUN_LEN = 11,
  parameter int ERR_SRC = 3
)(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobes,
  input  logic               rxBit,
  input  logic               bitStrobe,
  input  logic               sofPulse,
  input  logic [ERR_SRC-1:0] errStatus,
  input  logic [ERR_SRC-1:0] errIntEn,
  input  logic               wakeIntEn,
  input  logic               flagWrEn,
  input  logic [1:0]         flagWrData,
  output logic               runDone,
  output logic               wakeFlag,
  output logic               errFlag,
  output logic               statusIrq
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] runCnt;
  logic             wakeSet, errSet, wakeClr, errClr;
  logic [ERR_SRC-1:0] errHit;

  assign runDone = strobes.exitWait && bitStrobe && rxBit && (runCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runCnt <= '0;
    else if (!strobes.exitWait) runCnt <= '0;
    else if (bitStrobe) begin
      if (!rxBit)       runCnt <= '0;
      else if (runDone) runCnt <= '0;
      else              runCnt <= runCnt + 1'b1;
    end
  end

  // per-source gating of the error status
  for (genvar i = 0; i < ERR_SRC; i++) begin : g_errGate
    assign errHit[i] = errStatus[i] & errIntEn[i];
  end

  assign wakeSet = sofPulse && strobes.sleepActive;
  assign errSet  = |errHit;
  assign wakeClr = flagWrEn && flagWrData[0];
  assign errClr  = flagWrEn && flagWrData[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeFlag  <= 1'b0;
      errFlag   <= 1'b0;
      statusIrq <= 1'b0;
    end else begin
      if (wakeSet)      wakeFlag <= 1'b1;
      else if (wakeClr) wakeFlag <= 1'b0;
      if (errSet)       errFlag <= 1'b1;
      else if (errClr)  errFlag <= 1'b0;
      statusIrq <= (wakeFlag && wakeIntEn) || errFlag;
    end
  end

  // R4: the run counter stays below the run length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < CNT_W'(RUN_LEN));

  // R4: a dominant bit restarts the run
  p_dominant_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.exitWait && bitStrobe && !rxBit) |=> (runCnt == '0));

  // R9: a hardware set always leaves the flag set
  p_wake_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    wakeSet |=> wakeFlag);

  // R6: the wakeup flag only rises on a SOF during sleep
  p_wake_only_sleep_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> $past(sofPulse && strobes.sleepActive));

  // R10: a set error flag is followed by the interrupt
  p_err_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> statusIrq);

endmodule

// File: rtl/can_lpm_seq.sv
module can_lpm_seq
  import can_lpm_pkg::*;
#(
  parameter int RUN_LEN = 11,
  parameter int ERR_SRC = 3
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepReq,
  input  logic               freezeReq,
  input  logic               busBusy,
  input  logic               rxBit,
  input  logic               bitStrobe,
  input  logic               sofPulse,
  input  logic [ERR_SRC-1:0] errStatus,
  input  logic [ERR_SRC-1:0] errIntEn,
  input  logic               wakeIntEn,
  input  logic               flagWrEn,
  input  logic [1:0]         flagWrData,
  output logic               sleepAck,
  output logic               freezeAck,
  output logic               wakeFlag,
  output logic               errFlag,
  output logic               statusIrq
);

  ctrlStrobe_t strobes;
  logic        runDone;

  can_lpm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sleepReq  (sleepReq),
    .freezeReq (freezeReq),
    .busBusy   (busBusy),
    .runDone   (runDone),
    .strobes   (strobes),
    .sleepAck  (sleepAck),
    .freezeAck (freezeAck)
  );

  can_lpm_dp #(.RUN_LEN(RUN_LEN), .ERR_SRC(ERR_SRC)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rxBit      (rxBit),
    .bitStrobe  (bitStrobe),
    .sofPulse   (sofPulse),
    .errStatus  (errStatus),
    .errIntEn   (errIntEn),
    .wakeIntEn  (wakeIntEn),
    .flagWrEn   (flagWrEn),
    .flagWrData (flagWrData),
    .runDone    (runDone),
    .wakeFlag   (wakeFlag),
    .errFlag    (errFlag),
    .statusIrq  (statusIrq)
  );

endmodule

// File: tb/tb_can_lpm_seq.sv
module tb_can_lpm_seq;

  localparam int CLK_P   = 10;
  localparam int RUN_LEN = 11;
  localparam int ERR_SRC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b1, freezeReq = 1'b0, busBusy = 1'b0;
  logic rxBit = 1'b1, bitStrobe = 1'b0, sofPulse = 1'b0;
  logic [ERR_SRC-1:0] errStatus = '0, errIntEn = '0;
  logic wakeIntEn = 1'b0, flagWrEn = 1'b0;
  logic [1:0] flagWrData = '0;
  logic sleepAck, freezeAck, wakeFlag, errFlag, statusIrq;

  int nChecks = 0;
  int nFails  = 0;

  // reference model: 0 normal, 1 sleep, 2 sleep exit, 3 freeze, 4 freeze exit
  int mMode = 1;
  int mCnt  = 0;
  bit mWake = 0, mErr = 0, mIrq = 0;

  always #(CLK_P/2) clk = ~clk;

  can_lpm_seq #(.RUN_LEN(RUN_LEN), .ERR_SRC(ERR_SRC)) dut (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .freezeReq(freezeReq),
    .busBusy(busBusy), .rxBit(rxBit), .bitStrobe(bitStrobe), .sofPulse(sofPulse),
    .errStatus(errStatus), .errIntEn(errIntEn), .wakeIntEn(wakeIntEn),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData), .sleepAck(sleepAck),
    .freezeAck(freezeAck), .wakeFlag(wakeFlag), .errFlag(errFlag), .statusIrq(statusIrq)
  );

  function automatic bit expSleepAck(int m);
    return (m == 1) || (m == 2);
  endfunction

  function automatic bit expFreezeAck(int m);
    return (m == 3) || (m == 4);
  endfunction

  task automatic chk(input bit got, input bit exp, input string tag);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    bit inWait, done, sAct;
    int nMode, nCnt;
    bit nWake, nErr, nIrq;
    inWait = (mMode == 2) || (mMode == 4);
    sAct   = expSleepAck(mMode);
    done   = inWait && bitStrobe && rxBit && (mCnt == RUN_LEN - 1);
    nIrq   = (mWake && wakeIntEn) || mErr;
    nWake  = (sofPulse && sAct) ? 1'b1 : ((flagWrEn && flagWrData[0]) ? 1'b0 : mWake);
    nErr   = (|(errStatus & errIntEn)) ? 1'b1 : ((flagWrEn && flagWrData[1]) ? 1'b0 : mErr);
    if (!inWait) nCnt = 0;
    else if (bitStrobe) nCnt = rxBit ? (done ? 0 : mCnt + 1) : 0;
    else nCnt = mCnt;
    nMode = mMode;
    case (mMode)
      0: if (!busBusy) begin
           if (freezeReq) nMode = 3;
           else if (sleepReq) nMode = 1;
         end
      1: if (!sleepReq) nMode = 2;
      2: if (sleepReq) nMode = 1; else if (done) nMode = 0;
      3: if (!freezeReq) nMode = 4;
      4: if (freezeReq) nMode = 3; else if (done) nMode = 0;
      default: nMode = mMode;
    endcase
    @(posedge clk);
    mMode = nMode; mCnt = nCnt; mWake = nWake; mErr = nErr; mIrq = nIrq;
    #1;
    chk(sleepAck,  expSleepAck(mMode),  "R2/R3 sleepAck");
    chk(freezeAck, expFreezeAck(mMode), "R2/R3 freezeAck");
    chk(wakeFlag,  mWake, "R6/R8/R9 wakeFlag");
    chk(errFlag,   mErr,  "R7/R8 errFlag");
    chk(statusIrq, mIrq,  "R10 statusIrq");
  endtask

  task automatic idleIn();
    sofPulse = 0; flagWrEn = 0; flagWrData = '0; errStatus = '0; bitStrobe = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    #(CLK_P * 2 + 1);
    chk(sleepAck, 1'b1, "R1 reset sleepAck");
    chk(freezeAck, 1'b0, "R1 reset freezeAck");
    chk(wakeFlag | errFlag | statusIrq, 1'b0, "R1 reset flags");
    rstN = 1'b1;
    @(negedge clk);

    // R6: SOF while asleep; R9: same-cycle clear loses
    sofPulse = 1; flagWrEn = 1; flagWrData = 2'b01; step();
    chk(wakeFlag, 1'b1, "R9 set beats clear");
    idleIn(); wakeIntEn = 1; step(); step();
    chk(statusIrq, 1'b1, "R10 irq from wake");
    flagWrEn = 1; flagWrData = 2'b10; step(); idleIn();
    chk(wakeFlag, 1'b1, "R8 write zero keeps wake");
    flagWrEn = 1; flagWrData = 2'b01; step(); idleIn();
    chk(wakeFlag, 1'b0, "R8 write one clears wake");

    // R3/R4: exit with a dominant bit one short of the run
    sleepReq = 0; step();
    bitStrobe = 1; rxBit = 1;
    for (int i = 0; i < RUN_LEN - 1; i++) step();
    rxBit = 0; step(); rxBit = 1;
    chk(sleepAck, 1'b1, "R4 dominant restarts run");
    bitStrobe = 0; rxBit = 0; step(); step();
    chk(sleepAck, 1'b1, "R4 rx without strobe ignored");
    bitStrobe = 1; rxBit = 1;
    for (int i = 0; i < RUN_LEN - 1; i++) step();
    chk(sleepAck, 1'b1, "R3 one bit short");
    step();
    chk(sleepAck, 1'b0, "R3 exit after full run");
    bitStrobe = 0;

    // R6: SOF outside sleep has no effect
    sofPulse = 1; step(); sofPulse = 0;
    chk(wakeFlag, 1'b0, "R6 SOF ignored when awake");

    // R5: withdrawn request while busy
    busBusy = 1; freezeReq = 1; step(); step();
    chk(freezeAck, 1'b0, "R2 no entry while busy");
    freezeReq = 0; busBusy = 0; step(); step();
    chk(freezeAck | sleepAck, 1'b0, "R5 withdrawn request stays normal");

    // R2: freeze has priority
    freezeReq = 1; sleepReq = 1; step();
    chk(freezeAck, 1'b1, "R2 freeze priority");
    chk(sleepAck, 1'b0, "R2 sleep not entered");
    sleepReq = 0;

    // R7: error gating per source
    errStatus = 3'b101; errIntEn = 3'b010; step();
    chk(errFlag, 1'b0, "R7 disabled sources ignored");
    errIntEn = 3'b100; step(); errStatus = '0;
    chk(errFlag, 1'b1, "R7 enabled source sets");
    flagWrEn = 1; flagWrData = 2'b10; step(); idleIn();
    chk(errFlag, 1'b0, "R8 clear error");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 29) == 0) sleepReq = ~sleepReq;
      if ($urandom_range(0, 39) == 0) freezeReq = ~freezeReq;
      busBusy    = ($urandom_range(0, 3) == 0);
      bitStrobe  = ($urandom_range(0, 2) != 0);
      rxBit      = ($urandom_range(0, 24) != 0);
      sofPulse   = ($urandom_range(0, 19) == 0);
      errStatus  = ($urandom_range(0, 15) == 0) ? ERR_SRC'($urandom) : '0;
      errIntEn   = ERR_SRC'($urandom);
      wakeIntEn  = $urandom_range(0, 1);
      flagWrEn   = ($urandom_range(0, 7) == 0);
      flagWrData = 2'($urandom);
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule